// File: doc/BRIEF.md
# Periodic Split-Transaction Pipeline

This block carries the scheduled (interrupt and isochronous) traffic of a hub that bridges a high-speed upstream link to a full/low-speed downstream bus. Three handlers share the work. The start handler accepts start-split requests from the upstream side and queues them in arrival order. The downstream handler takes one queued entry at a time and presents it on an abstract transaction port. It then waits for the outcome and stores the outcome in a result queue. The complete handler answers complete-split requests from the front of the result queue.

The host computes the schedule, so the block never reorders work. A complete-split that names an address other than the one at the front of the result queue gets a "not yet" reply. A result that waits too long is thrown away when a microframe tick arrives, and each discarded result is counted. While any scheduled work is queued or running, a pending output tells the non-periodic side to hold off its own downstream traffic.

Top module: `psplit_pipe`

## Requirements
- R1: Accepted start-splits reach the downstream port in the order they arrived, one entry per downstream transaction, with the address, direction and isochronous flag of the request.
- R2: A start-split that arrives while the start queue holds DEPTH entries is dropped and never reaches the downstream port. It sets `overflowFlag`, which stays set until reset.
- R3: `dsReqValid` rises when an entry is taken from the start queue and stays high, with all request fields unchanged, until the cycle in which `dsDone` is sampled high. Only one transaction is outstanding at a time. OUT data equals the data of the start-split.
- R4: A complete-split whose address matches the oldest stored result is answered one cycle later with `csRspValid`=1. For a non-isochronous entry the reply has kind 1, the handshake given with `dsDone`, and data equal to `dsInData` for IN or 0 for OUT. The result is then removed.
- R5: For an isochronous entry the reply has kind 2 and `csRspHsk`=0, whatever handshake was reported downstream.
- R6: A complete-split that arrives when the result queue is empty, or when the oldest result belongs to another address, is answered one cycle later with kind 0 (not yet). It removes nothing, so a later matching complete-split still gets the result.
- R7: Each `uframeTick` ages every stored result by one. A result that has already seen two ticks is discarded at the third tick. `errCount` then grows by the number of results discarded at that tick, which can be more than one.
- R8: `periodicPending` is 1 whenever the start queue is non-empty or a downstream transaction is outstanding, and 0 otherwise.
- R9: No new downstream transaction starts while the result queue holds DEPTH entries. The waiting entry starts once a complete-split frees a slot.
- R10: After reset, `dsReqValid`, `periodicPending`, `overflowFlag`, `csRspValid` and `errCount` are all 0 and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| uframeTick | input | 1 | One-cycle pulse at each microframe boundary |
| ssValid | input | 1 | Start-split request strobe |
| ssAddr | input | ADDR_W | Endpoint address of the start-split |
| ssIsIn | input | 1 | 1 = IN transfer, 0 = OUT |
| ssIsIso | input | 1 | 1 = isochronous, 0 = interrupt |
| ssData | input | DATA_W | OUT payload |
| dsReqValid | output | 1 | Downstream transaction outstanding |
| dsReqAddr | output | ADDR_W | Downstream address |
| dsReqIsIn | output | 1 | Downstream direction |
| dsReqIsIso | output | 1 | Downstream isochronous flag |
| dsReqData | output | DATA_W | Downstream OUT payload |
| dsDone | input | 1 | Downstream outcome strobe |
| dsHsk | input | HSK_W | Downstream handshake code |
| dsInData | input | DATA_W | Data returned by an IN transfer |
| csValid | input | 1 | Complete-split request strobe |
| csAddr | input | ADDR_W | Address named by the complete-split |
| csRspValid | output | 1 | Complete-split reply strobe |
| csRspKind | output | 2 | 0 not yet, 1 result with handshake, 2 isochronous result |
| csRspHsk | output | HSK_W | Returned handshake |
| csRspData | output | DATA_W | Returned data |
| periodicPending | output | 1 | Scheduled work queued or running |
| overflowFlag | output | 1 | Sticky start-queue overflow |
| errCount | output | ERR_W | Results discarded for age |

## Verification
The assertions assume that the downstream side raises `dsDone` only while `dsReqValid` is high. They also assume that `uframeTick`, `ssValid` and `csValid` are single-cycle strobes driven between clock edges. The stimulus answers each downstream request exactly once, after it has seen `dsReqValid` high, and pulses every strobe for exactly one cycle. Address bits select the direction and isochronous flag in the sweeps, so every combination of IN/OUT and interrupt/isochronous passes through the queues at several fill levels.

// File: rtl/psplit_pkg.sv
package psplit_pkg;

  typedef enum logic [1:0] {
    RSP_NYET = 2'd0,
    RSP_HSK  = 2'd1,
    RSP_ISO  = 2'd2
  } rsp_kind_e;

  typedef struct packed {
    logic ssPush;
    logic ovfSet;
    logic issue;
    logic resPush;
    logic csAnswer;
    logic csPop;
  } strobes_t;

endpackage

// File: rtl/psplit_ctrl.sv
module psplit_ctrl
  import psplit_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ssValid,
  input  logic     ssFull,
  input  logic     ssEmpty,
  input  logic     resFull,
  input  logic     dsDone,
  input  logic     csValid,
  input  logic     headMatch,
  output strobes_t strb,
  output logic     busy,
  output logic     overflowFlag
);

  always_comb begin
    strb.ssPush   = ssValid && !ssFull;
    strb.ovfSet   = ssValid && ssFull;
    strb.issue    = !busy && !ssEmpty && !resFull;
    strb.resPush  = busy && dsDone;
    strb.csAnswer = csValid;
    strb.csPop    = csValid && headMatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy         <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      if (strb.issue)        busy <= 1'b1;
      else if (strb.resPush) busy <= 1'b0;
      if (strb.ovfSet) overflowFlag <= 1'b1;
    end
  end

  // R3: one transaction at a time; a completion ends it
  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    strb.resPush |=> !busy);

  // R2: overflow flag is sticky
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

endmodule

// File: rtl/psplit_dp.sv
module psplit_dp
  import psplit_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int HSK_W  = 2,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic              uframeTick,
  input  logic [ADDR_W-1:0] ssAddr,
  input  logic              ssIsIn,
  input  logic              ssIsIso,
  input  logic [DATA_W-1:0] ssData,
  input  logic [HSK_W-1:0]  dsHsk,
  input  logic [DATA_W-1:0] dsInData,
  input  logic [ADDR_W-1:0] csAddr,
  output logic              ssFull,
  output logic              ssEmpty,
  output logic              resFull,
  output logic              headMatch,
  output logic [ADDR_W-1:0] dsReqAddr,
  output logic              dsReqIsIn,
  output logic              dsReqIsIso,
  output logic [DATA_W-1:0] dsReqData,
  output logic              csRspValid,
  output rsp_kind_e         csRspKind,
  output logic [HSK_W-1:0]  csRspHsk,
  output logic [DATA_W-1:0] csRspData,
  output logic [ERR_W-1:0]  errCount
);

  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = PW + 1;
  localparam int REQ_W = ADDR_W + 2 + DATA_W;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // start-split queue
  logic [REQ_W-1:0] ssMem [DEPTH];
  logic [CW-1:0]    ssWr, ssRd, ssCnt;

  // result queue
  logic [ADDR_W-1:0] resAddr [DEPTH];
  logic              resIso  [DEPTH];
  logic [HSK_W-1:0]  resHsk  [DEPTH];
  logic [DATA_W-1:0] resData [DEPTH];
  logic [1:0]        resAge  [DEPTH];
  logic [DEPTH-1:0]  resVld;
  logic [CW-1:0]     resWr, resRd, resCnt;
  logic [PW-1:0]     headIdx, resWrIdx;
  logic [DEPTH-1:0]  staleVec;
  logic [CW-1:0]     dropCnt;

  assign ssCnt     = ssWr - ssRd;
  assign ssFull    = (ssCnt == FULL_CNT);
  assign ssEmpty   = (ssCnt == '0);
  assign resCnt    = resWr - resRd;
  assign resFull   = (resCnt == FULL_CNT);
  assign headIdx   = resRd[PW-1:0];
  assign resWrIdx  = resWr[PW-1:0];
  assign headMatch = (resCnt != '0) && (resAddr[headIdx] == csAddr);

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      staleVec[i] = uframeTick && resVld[i] && (resAge[i] == 2'd2)
                    && !(strb.csPop && (headIdx == PW'(i)));
    dropCnt = CW'($countones(staleVec));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ssWr       <= '0;
      ssRd       <= '0;
      resWr      <= '0;
      resRd      <= '0;
      resVld     <= '0;
      dsReqAddr  <= '0;
      dsReqIsIn  <= 1'b0;
      dsReqIsIso <= 1'b0;
      dsReqData  <= '0;
      csRspValid <= 1'b0;
      csRspKind  <= RSP_NYET;
      csRspHsk   <= '0;
      csRspData  <= '0;
      errCount   <= '0;
    end else begin
      if (strb.ssPush) begin
        ssMem[ssWr[PW-1:0]] <= {ssAddr, ssIsIn, ssIsIso, ssData};
        ssWr <= ssWr + 1'b1;
      end
      if (strb.issue) begin
        {dsReqAddr, dsReqIsIn, dsReqIsIso, dsReqData} <= ssMem[ssRd[PW-1:0]];
        ssRd <= ssRd + 1'b1;
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (uframeTick && resVld[i]) resAge[i] <= resAge[i] + 2'd1;
        if (staleVec[i])             resVld[i] <= 1'b0;
      end
      if (strb.csPop) resVld[headIdx] <= 1'b0;
      if (strb.resPush) begin
        resAddr[resWrIdx] <= dsReqAddr;
        resIso[resWrIdx]  <= dsReqIsIso;
        resHsk[resWrIdx]  <= dsReqIsIso ? '0 : dsHsk;
        resData[resWrIdx] <= dsReqIsIn ? dsInData : '0;
        resAge[resWrIdx]  <= 2'd0;
        resVld[resWrIdx]  <= 1'b1;
        resWr <= resWr + 1'b1;
      end
      resRd    <= resRd + CW'(strb.csPop) + dropCnt;
      errCount <= errCount + ERR_W'(dropCnt);

      csRspValid <= strb.csAnswer;
      if (strb.csPop) begin
        csRspKind <= resIso[headIdx] ? RSP_ISO : RSP_HSK;
        csRspHsk  <= resHsk[headIdx];
        csRspData <= resData[headIdx];
      end else begin
        csRspKind <= RSP_NYET;
        csRspHsk  <= '0;
        csRspData <= '0;
      end
    end
  end

  // R2: control never pushes into a full start queue
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.ssPush |-> (ssCnt != FULL_CNT));

  // R1: an issue always takes a real entry
  a_r1_issue_has_entry: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (ssCnt != '0));

  // R9: a result is never pushed into a full result queue
  a_r9_result_room: assert property (@(posedge clk) disable iff (!rstN)
    strb.resPush |-> (resCnt != FULL_CNT));

  // R6: an unmatched complete-split gets a not-yet reply
  a_r6_nyet_reply: assert property (@(posedge clk) disable iff (!rstN)
    (strb.csAnswer && !strb.csPop) |=> (csRspKind == RSP_NYET));

  // R5: isochronous replies never carry a handshake
  a_r5_iso_no_hsk: assert property (@(posedge clk) disable iff (!rstN)
    (csRspValid && csRspKind == RSP_ISO) |-> (csRspHsk == '0));

endmodule

// File: rtl/psplit_pipe.sv
module psplit_pipe
  import psplit_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int HSK_W  = 2,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              uframeTick,
  input  logic              ssValid,
  input  logic [ADDR_W-1:0] ssAddr,
  input  logic              ssIsIn,
  input  logic              ssIsIso,
  input  logic [DATA_W-1:0] ssData,
  output logic              dsReqValid,
  output logic [ADDR_W-1:0] dsReqAddr,
  output logic              dsReqIsIn,
  output logic              dsReqIsIso,
  output logic [DATA_W-1:0] dsReqData,
  input  logic              dsDone,
  input  logic [HSK_W-1:0]  dsHsk,
  input  logic [DATA_W-1:0] dsInData,
  input  logic              csValid,
  input  logic [ADDR_W-1:0] csAddr,
  output logic              csRspValid,
  output logic [1:0]        csRspKind,
  output logic [HSK_W-1:0]  csRspHsk,
  output logic [DATA_W-1:0] csRspData,
  output logic              periodicPending,
  output logic              overflowFlag,
  output logic [ERR_W-1:0]  errCount
);

  strobes_t  strb;
  logic      ssFull, ssEmpty, resFull, headMatch, busy;
  rsp_kind_e rspKind;

  psplit_ctrl u_ctrl (
    .clk, .rstN, .ssValid, .ssFull, .ssEmpty, .resFull, .dsDone,
    .csValid, .headMatch, .strb, .busy, .overflowFlag
  );

  psplit_dp #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HSK_W(HSK_W), .ERR_W(ERR_W)
  ) u_dp (
    .clk, .rstN, .strb, .uframeTick, .ssAddr, .ssIsIn, .ssIsIso, .ssData,
    .dsHsk, .dsInData, .csAddr, .ssFull, .ssEmpty, .resFull, .headMatch,
    .dsReqAddr, .dsReqIsIn, .dsReqIsIso, .dsReqData, .csRspValid,
    .csRspKind(rspKind), .csRspHsk, .csRspData, .errCount
  );

  assign dsReqValid      = busy;
  assign csRspKind       = rspKind;
  assign periodicPending = busy || !ssEmpty;

  // R3: request held steady until the outcome arrives
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (dsReqValid && !dsDone) |=> (dsReqValid && $stable(dsReqAddr) && $stable(dsReqData)
                                 && $stable(dsReqIsIn) && $stable(dsReqIsIso)));

  // R8: an outstanding transaction always shows as pending
  a_r8_pending_busy: assert property (@(posedge clk) disable iff (!rstN)
    dsReqValid |-> periodicPending);

  // R4: every reply answers a complete-split of the previous cycle
  a_r4_reply_timing: assert property (@(posedge clk) disable iff (!rstN)
    csRspValid |-> $past(csValid));

endmodule

// File: tb/psplit_pipe_bench.sv
module psplit_pipe_bench;
  localparam int DEPTH = 8;
  localparam int AW = 7;
  localparam int DW = 8;
  localparam int HW = 2;
  localparam int EW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN, uframeTick, ssValid, ssIsIn, ssIsIso, dsDone, csValid;
  logic [AW-1:0] ssAddr, csAddr, dsReqAddr;
  logic [DW-1:0] ssData, dsInData, dsReqData, csRspData;
  logic [HW-1:0] dsHsk, csRspHsk;
  logic          dsReqValid, dsReqIsIn, dsReqIsIso, csRspValid;
  logic [1:0]    csRspKind;
  logic          periodicPending, overflowFlag;
  logic [EW-1:0] errCount;

  psplit_pipe #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .HSK_W(HW), .ERR_W(EW)) u_psplit_pipe (
    .clk, .rstN, .uframeTick, .ssValid, .ssAddr, .ssIsIn, .ssIsIso, .ssData,
    .dsReqValid, .dsReqAddr, .dsReqIsIn, .dsReqIsIso, .dsReqData,
    .dsDone, .dsHsk, .dsInData, .csValid, .csAddr,
    .csRspValid, .csRspKind, .csRspHsk, .csRspData,
    .periodicPending, .overflowFlag, .errCount
  );

  int nChecks = 0;
  int nErr = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Field patterns derived from the address: bit0 = IN, bit1 = isochronous
  function automatic logic [DW-1:0] outData(input logic [AW-1:0] a);
    return DW'(a * 3 + 1);
  endfunction
  function automatic logic [DW-1:0] inData(input logic [AW-1:0] a);
    return DW'({1'b0, a}) ^ 8'h5A;
  endfunction
  function automatic logic [1:0] expKind(input logic [AW-1:0] a);
    return a[1] ? 2'd2 : 2'd1;
  endfunction
  function automatic logic [HW-1:0] expHsk(input logic [AW-1:0] a);
    return a[1] ? '0 : a[1:0];
  endfunction
  function automatic logic [DW-1:0] expData(input logic [AW-1:0] a);
    return a[0] ? inData(a) : '0;
  endfunction

  task automatic pushSs(input logic [AW-1:0] a);
    ssValid = 1'b1; ssAddr = a; ssIsIn = a[0]; ssIsIso = a[1]; ssData = outData(a);
    @(negedge clk);
    ssValid = 1'b0;
  endtask

  task automatic serve(input logic [AW-1:0] a);
    int w = 0;
    while (!dsReqValid && w < 50) begin
      @(negedge clk);
      w++;
    end
    chk("R3 request present", dsReqValid, 1);
    chk("R1 request order/address", dsReqAddr, a);
    chk("R1 request direction", dsReqIsIn, a[0]);
    chk("R1 request iso flag", dsReqIsIso, a[1]);
    chk("R3 OUT payload", dsReqData, outData(a));
    dsDone = 1'b1; dsHsk = a[1:0]; dsInData = inData(a);
    @(negedge clk);
    dsDone = 1'b0;
  endtask

  task automatic compl(input logic [AW-1:0] a, input bit hit);
    csValid = 1'b1; csAddr = a;
    @(negedge clk);
    csValid = 1'b0;
    chk("R4 reply strobe", csRspValid, 1);
    if (hit) begin
      chk("R4 R5 reply kind", csRspKind, expKind(a));
      chk("R5 reply handshake", csRspHsk, expHsk(a));
      chk("R4 reply data", csRspData, expData(a));
    end else begin
      chk("R6 not-yet reply", csRspKind, 0);
    end
  endtask

  task automatic tickOnce();
    uframeTick = 1'b1;
    @(negedge clk);
    uframeTick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog R3 actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    rstN = 1'b0; uframeTick = 0; ssValid = 0; ssAddr = '0; ssIsIn = 0; ssIsIso = 0;
    ssData = '0; dsDone = 0; dsHsk = '0; dsInData = '0; csValid = 0; csAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 dsReqValid", dsReqValid, 0);
    chk("R10 periodicPending", periodicPending, 0);
    chk("R10 overflowFlag", overflowFlag, 0);
    chk("R10 errCount", errCount, 0);
    chk("R10 csRspValid", csRspValid, 0);
    compl(7'h7F, 0);  // R6 empty queue

    // Sweep over fill levels 1..4, all IN/OUT x int/iso combinations
    for (int n = 1; n <= 4; n++) begin
      for (int i = 0; i < n; i++) pushSs(AW'(n * 16 + i));
      chk("R8 pending after push", periodicPending, 1);
      for (int i = 0; i < n; i++) serve(AW'(n * 16 + i));
      compl(7'h7F, 0);                       // R6 foreign address
      if (n > 1) compl(AW'(n * 16 + 1), 0);  // R6 second before first
      for (int i = 0; i < n; i++) compl(AW'(n * 16 + i), 1);
      repeat (2) @(negedge clk);
      chk("R8 idle after drain", periodicPending, 0);
      chk("R8 no request after drain", dsReqValid, 0);
    end

    // Overflow and result-queue back-pressure
    for (int i = 0; i < 9; i++) pushSs(AW'(64 + i));
    chk("R2 no overflow yet", overflowFlag, 0);
    pushSs(AW'(73));
    chk("R2 overflow set", overflowFlag, 1);
    for (int i = 0; i < 8; i++) serve(AW'(64 + i));
    repeat (3) @(negedge clk);
    chk("R9 stalled while result queue full", dsReqValid, 0);
    chk("R9 R8 entry still pending", periodicPending, 1);
    compl(AW'(64), 1);
    serve(AW'(72));
    for (int i = 1; i < 9; i++) compl(AW'(64 + i), 1);
    repeat (3) @(negedge clk);
    chk("R2 dropped entry never issued", dsReqValid, 0);
    chk("R2 R8 nothing left pending", periodicPending, 0);
    chk("R2 flag sticky", overflowFlag, 1);

    // Ageing
    pushSs(AW'(80)); pushSs(AW'(81));
    serve(AW'(80)); serve(AW'(81));
    tickOnce(); tickOnce();
    chk("R7 no drop after two ticks", errCount, 0);
    compl(AW'(80), 1);
    tickOnce();
    chk("R7 single drop at third tick", errCount, 1);
    compl(AW'(81), 0);
    pushSs(AW'(82)); pushSs(AW'(83));
    serve(AW'(82)); serve(AW'(83));
    tickOnce(); tickOnce(); tickOnce();
    chk("R7 double drop counted", errCount, 3);
    compl(AW'(82), 0);
    pushSs(AW'(85));
    serve(AW'(85));
    compl(AW'(85), 1);  // R7 queue usable after drops

    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule